// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Holding Latches

This block keeps the instruction address of a small microcontroller core. The counter is 21 bits wide and addresses bytes, but it always points at an even address, so sequential execution moves it forward by two. The instruction decoder can overwrite the whole counter at once for jumps, calls, relative calls and branches.

Software reaches the counter only through a narrow data-bus register port. The low byte of the counter can be read and written directly. The two upper parts of the counter are hidden and are reached through two holding latches. A write of the low byte moves both latch values into the upper counter bits in the same update. A read of the low byte copies the current upper counter bits back into the latches. This supports computed jumps: software sets the latches first and then writes an offset into the low byte.

Top module: `prog_addr_ctr`

## Requirements
- R1: After an active-low reset, the counter and both latches are 0.
- R2: `reg_sel` selects the register for data-bus access: 0 is the counter low byte, 1 is the high latch (8 bits), 2 is the upper latch (5 bits) and 3 is no register. `rd_data` shows the selected register in the same cycle. For select 3, reads return 0 and writes are ignored.
- R3: A write with select 0 loads the counter on the next clock edge with {upper latch, high latch, written byte}. Bit 0 is forced to 0.
- R4: A read with select 0 returns counter bits 7:0. On that clock edge it also copies counter bits 15:8 into the high latch and bits 20:16 into the upper latch.
- R5: Counter bit 0 is always 0. Odd values from a low-byte write or a direct load have bit 0 cleared.
- R6: When `adv_en` is set, the counter increases by 2. From 0x1FFFFE it wraps to 0.
- R7: A direct load (`ld_en`) writes `ld_addr`, with bit 0 cleared, into the whole counter. It leaves both latches unchanged.
- R8: When several updates occur in the same cycle, the priority is: direct load first, then low-byte write, then advance.
- R9: Bits 7:5 written to the upper latch are dropped. When the upper latch is read, those bits read as 0.
- R10: Writing either latch does not change the counter. The counter bits above bit 7 change only through a low-byte write, a direct load or an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Data-bus register select (encoding in R2) |
| reg_wr | input | 1 | Data-bus write strobe |
| reg_rd | input | 1 | Data-bus read strobe |
| wr_data | input | 8 | Data-bus write data |
| rd_data | output | 8 | Data-bus read data for the selected register |
| ld_en | input | 1 | Direct-load strobe from the decoder |
| ld_addr | input | 21 | Direct-load target address |
| adv_en | input | 1 | Sequential-advance strobe |
| pc_out | output | 21 | Full counter value |

## Verification
The bench builds the block with its default parameters: a 21-bit counter with an 8-bit data bus, which gives a 5-bit upper latch. With this width, direct loads can reach the top address 0x1FFFFE, so the wrap from a single advance can be checked. The 8-bit bus is wider than the 5-bit latch, so the bench can write the dropped upper-latch bits and read back that they return as 0. All three sources that can update the counter can be driven in the same cycle, which exercises each priority pairing.

// File: rtl/pac_pkg.sv
// Shared types for the program address counter.
// Assumes a two-bit data-bus register select.
package pac_pkg;
    typedef enum logic [1:0] {
        SEL_LOW   = 2'd0,
        SEL_HIGH  = 2'd1,
        SEL_UPPER = 2'd2,
        SEL_NONE  = 2'd3
    } pac_sel_e;
endpackage

// File: rtl/pac_latch_bank.sv
// Holding latches for the hidden counter bits.
// Bus writes load a latch directly. A capture strobe copies the counter's
// upper bits into both latches. Assumes write and capture never target the
// same latch in one cycle; if they do, the write wins.
module pac_latch_bank #(
    parameter int DATA_W = 8,
    parameter int UP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_up,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_hi,
    input  logic [UP_W-1:0]   cap_up,
    output logic [DATA_W-1:0] hi_q,
    output logic [UP_W-1:0]   up_q
);
    // High latch: bus write, else capture from the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (wr_hi)  hi_q <= wr_data;
        else if (cap_en) hi_q <= cap_hi;
    end

    // Upper latch: keeps only the low UP_W bits of a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)      up_q <= '0;
        else if (wr_up)  up_q <= wr_data[UP_W-1:0];
        else if (cap_en) up_q <= cap_up;
    end
endmodule

// File: rtl/pac_next_pc.sv
// Next-value logic for the counter.
// Priority: direct load, then low-byte write with latch transfer, then
// advance by two. Every result has bit 0 cleared. Assumes ADDR_W > 2*DATA_W.
module pac_next_pc #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8,
    parameter int UP_W   = ADDR_W - 2*DATA_W
) (
    input  logic [ADDR_W-1:0] pc_q,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              low_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] hi_q,
    input  logic [UP_W-1:0]   up_q,
    input  logic              adv_en,
    output logic [ADDR_W-1:0] pc_d
);
    localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(2);

    logic [ADDR_W-1:0] joined;

    // Counter value built from the latches and the written low byte.
    always_comb joined = {up_q, hi_q, wr_data};

    // Pick the next counter value in priority order.
    always_comb begin
        if (ld_en)       pc_d = ld_addr & EVEN_MASK;
        else if (low_wr) pc_d = joined & EVEN_MASK;
        else if (adv_en) pc_d = (pc_q + STEP) & EVEN_MASK;
        else             pc_d = pc_q;
    end
endmodule

// File: rtl/pac_rd_mux.sv
// Read-data selection for the data-bus register port.
// Unselected or unused codes return zero. Assumes UP_W < DATA_W.
module pac_rd_mux
    import pac_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int UP_W   = 5
) (
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] pc_low,
    input  logic [DATA_W-1:0] hi_q,
    input  logic [UP_W-1:0]   up_q,
    output logic [DATA_W-1:0] rd_data
);
    pac_sel_e sel;

    // Decode the select code.
    always_comb sel = pac_sel_e'(reg_sel);

    // Drive the selected register value onto the read bus.
    always_comb begin
        unique case (sel)
            SEL_LOW:   rd_data = pc_low;
            SEL_HIGH:  rd_data = hi_q;
            SEL_UPPER: rd_data = {{(DATA_W-UP_W){1'b0}}, up_q};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/prog_addr_ctr.sv
// Byte-addressed program counter with holding latches for its upper bits.
// The low byte is visible on the data bus. The upper bits are reached only
// through the latches: a low-byte write transfers the latches into the
// counter, and a low-byte read copies the counter back into the latches.
// Assumes the decoder asserts at most one of reg_wr and reg_rd per register
// access.
module prog_addr_ctr
    import pac_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              adv_en,
    output logic [ADDR_W-1:0] pc_out
);
    localparam int UP_W = ADDR_W - 2*DATA_W;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic [DATA_W-1:0] hi_q;
    logic [UP_W-1:0]   up_q;
    logic              low_wr, low_rd, hi_wr, up_wr;

    // Decode data-bus strobes per register.
    always_comb begin
        low_wr = reg_wr && (reg_sel == SEL_LOW);
        low_rd = reg_rd && (reg_sel == SEL_LOW);
        hi_wr  = reg_wr && (reg_sel == SEL_HIGH);
        up_wr  = reg_wr && (reg_sel == SEL_UPPER);
    end

    pac_latch_bank #(.DATA_W(DATA_W), .UP_W(UP_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (hi_wr),
        .wr_up   (up_wr),
        .wr_data (wr_data),
        .cap_en  (low_rd),
        .cap_hi  (pc_q[2*DATA_W-1:DATA_W]),
        .cap_up  (pc_q[ADDR_W-1:2*DATA_W]),
        .hi_q    (hi_q),
        .up_q    (up_q)
    );

    pac_next_pc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UP_W(UP_W)) u_next (
        .pc_q    (pc_q),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .low_wr  (low_wr),
        .wr_data (wr_data),
        .hi_q    (hi_q),
        .up_q    (up_q),
        .adv_en  (adv_en),
        .pc_d    (pc_d)
    );

    pac_rd_mux #(.DATA_W(DATA_W), .UP_W(UP_W)) u_rd (
        .reg_sel (reg_sel),
        .pc_low  (pc_q[DATA_W-1:0]),
        .hi_q    (hi_q),
        .up_q    (up_q),
        .rd_data (rd_data)
    );

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    always_comb pc_out = pc_q;
endmodule

// File: rtl/prog_addr_ctr_chk.sv
// Checker for prog_addr_ctr, attached with bind. It observes the ports and
// the latch outputs.
module prog_addr_ctr_chk #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8,
    parameter int UP_W   = ADDR_W - 2*DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              ld_en,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              adv_en,
    input logic [ADDR_W-1:0] pc_out,
    input logic [DATA_W-1:0] hi_q,
    input logic [UP_W-1:0]   up_q
);
    localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(1);
    logic low_wr, low_rd;
    always_comb begin
        low_wr = reg_wr && reg_sel == 2'd0;
        low_rd = reg_rd && reg_sel == 2'd0;
    end

    a_r5_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        pc_out[0] == 1'b0);

    a_r3_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        (low_wr && !ld_en) |=>
        pc_out == ({$past(up_q), $past(hi_q), $past(wr_data)} & MASK));

    a_r4_read_copy: assert property (@(posedge clk) disable iff (!rst_n)
        low_rd |=> (hi_q == $past(pc_out[2*DATA_W-1:DATA_W])) &&
                   (up_q == $past(pc_out[ADDR_W-1:2*DATA_W])));

    a_r7_load_keeps_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !reg_wr && !reg_rd) |=>
        (pc_out == ($past(ld_addr) & MASK)) && $stable(hi_q) && $stable(up_q));

    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !ld_en && !low_wr) |=>
        pc_out == ADDR_W'($past(pc_out) + ADDR_W'(2)));

    a_r8_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && (low_wr || adv_en)) |=> pc_out == ($past(ld_addr) & MASK));

    a_r10_latch_write_no_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel != 2'd0 && !ld_en && !adv_en) |=> $stable(pc_out));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd2) |-> rd_data[DATA_W-1:UP_W] == '0);
endmodule

bind prog_addr_ctr prog_addr_ctr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data), .ld_en(ld_en),
    .ld_addr(ld_addr), .adv_en(adv_en), .pc_out(pc_out), .hi_q(hi_q),
    .up_q(up_q)
);

// File: tb/prog_addr_ctr_tb.sv
// Directed bench for prog_addr_ctr.
module prog_addr_ctr_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  wr_data = 8'd0;
    logic [7:0]  rd_data;
    logic        ld_en = 1'b0;
    logic [20:0] ld_addr = 21'd0;
    logic        adv_en = 1'b0;
    logic [20:0] pc_out;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_addr_ctr u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data),
        .ld_en(ld_en), .ld_addr(ld_addr), .adv_en(adv_en), .pc_out(pc_out)
    );

    task automatic check(input string req, input logic [20:0] act,
                         input logic [20:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
        end
    endtask

    task automatic clear_inputs;
        reg_wr = 0; reg_rd = 0; ld_en = 0; adv_en = 0; reg_sel = 2'd0;
    endtask

    // One cycle of stimulus; it returns at the next falling edge, after the update.
    task automatic step(input logic [1:0] sel, input logic wr,
                        input logic [7:0] d, input logic ld,
                        input logic [20:0] la, input logic adv);
        @(negedge clk);
        reg_sel = sel; reg_wr = wr; wr_data = d; ld_en = ld;
        ld_addr = la; adv_en = adv;
        @(negedge clk);
        clear_inputs();
    endtask

    // Bus read: samples rd_data in the same cycle and keeps the strobe for one edge.
    task automatic bus_read(input logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1;
        #1 val = rd_data;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 pc", pc_out, 21'd0);
        bus_read(2'd1, v); check("R1 high latch", {13'd0, v}, 21'd0);
        bus_read(2'd2, v); check("R1 upper latch", {13'd0, v}, 21'd0);
    endtask

    task automatic t_advance;
        for (int i = 0; i < 3; i++) step(2'd0, 0, 8'd0, 0, 21'd0, 1);
        check("R6 advance x3", pc_out, 21'd6);
    endtask

    task automatic t_latch_write;
        logic [7:0] v;
        step(2'd1, 1, 8'h12, 0, 21'd0, 0);
        step(2'd2, 1, 8'hE5, 0, 21'd0, 0);
        check("R10 pc after latch writes", pc_out, 21'd6);
        bus_read(2'd2, v); check("R9 upper latch", {13'd0, v}, 21'h05);
        bus_read(2'd1, v); check("R2 high latch", {13'd0, v}, 21'h12);
    endtask

    task automatic t_low_write;
        step(2'd0, 1, 8'h35, 0, 21'd0, 0);
        check("R3 R5 low write", pc_out, 21'h051234);
    endtask

    task automatic t_no_reg;
        logic [7:0] v;
        step(2'd3, 1, 8'hAA, 0, 21'd0, 0);
        check("R2 sel3 write pc", pc_out, 21'h051234);
        bus_read(2'd3, v); check("R2 sel3 read", {13'd0, v}, 21'd0);
        bus_read(2'd1, v); check("R2 sel3 write hi", {13'd0, v}, 21'h12);
    endtask

    task automatic t_load_and_read;
        logic [7:0] v;
        step(2'd0, 0, 8'd0, 1, 21'h1ABCDE, 0);
        check("R7 load", pc_out, 21'h1ABCDE);
        bus_read(2'd1, v); check("R7 high latch kept", {13'd0, v}, 21'h12);
        bus_read(2'd2, v); check("R7 upper latch kept", {13'd0, v}, 21'h05);
        bus_read(2'd0, v); check("R4 low read", {13'd0, v}, 21'hDE);
        bus_read(2'd1, v); check("R4 high copy", {13'd0, v}, 21'hBC);
        bus_read(2'd2, v); check("R4 upper copy", {13'd0, v}, 21'h1A);
        step(2'd0, 1, 8'h40, 0, 21'd0, 0);
        check("R3 computed jump", pc_out, 21'h1ABC40);
    endtask

    task automatic t_odd_and_wrap;
        step(2'd0, 0, 8'd0, 1, 21'h000101, 0);
        check("R5 odd load", pc_out, 21'h000100);
        step(2'd0, 0, 8'd0, 1, 21'h1FFFFE, 0);
        step(2'd0, 0, 8'd0, 0, 21'd0, 1);
        check("R6 wrap", pc_out, 21'd0);
    endtask

    task automatic t_priority;
        step(2'd0, 0, 8'd0, 1, 21'h003000, 1);
        check("R8 load over advance", pc_out, 21'h003000);
        step(2'd0, 1, 8'h77, 1, 21'h004002, 0);
        check("R8 load over low write", pc_out, 21'h004002);
        step(2'd0, 1, 8'h20, 0, 21'd0, 1);
        check("R8 low write over advance", pc_out, 21'h1ABC20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_advance();
        t_latch_write();
        t_low_write();
        t_no_reg();
        t_load_and_read();
        t_odd_and_wrap();
        t_priority();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule